// File: doc/BRIEF.md
# Scaled Variable Node Unit

This block is the bit-side processor of a layered-free, flooding min-sum decoder for a regular code in which every code bit takes part in three parity checks. On each accepted beat it takes the channel log-likelihood of one bit together with the three messages arriving from its checks. It returns one message per edge for the next check-side half-iteration, plus a hard decision for the bit. The surrounding storage, address sequencing and stopping rule belong to the enclosing decoder.

Each incoming check message is first multiplied by 0.75, built as a half plus a quarter from two arithmetic right shifts and one addition. This stands in for the ideal correction of about 0.8 that offsets the optimism of the min-sum rule. The message sent back on edge k is the channel value plus the scaled messages from the other two edges, which keeps a check's own opinion out of its reply. The sum over all four terms gives the hard decision. Every message is five-bit two's complement with two fraction bits, so one LSB is 0.25. Intermediate sums are eight bits wide, and outgoing messages saturate to the five-bit range. One register stage sits between inputs and outputs.

Top module: `vnu_core`

## Requirements
- R1: Each incoming check message c is scaled to floor(c/2) + floor(c/4) in LSB units, using arithmetic shifts that round toward negative infinity. For example, -1 becomes -2 and 15 becomes 10.
- R2: Outgoing message k equals the channel value plus the scaled messages of the two edges other than k. It carries no share of edge k's own input.
- R3: Outgoing messages saturate to the range -16..15 LSB (-8.00 to +7.75). A larger sum yields 15 and a smaller one yields -16.
- R4: hard_bit is 1 when the channel value plus all three scaled messages is below zero, and 0 otherwise.
- R5: out_valid is in_valid delayed by exactly one clock.
- R6: While rst is high at a clock edge, out_valid, hard_bit and all outgoing messages become 0.
- R7: On a clock where in_valid is low, var_msg_flat and hard_bit keep their previous values.
- R8: Edge k occupies bits [5k+4:5k] of both chk_msg_flat and var_msg_flat, so edge 0 sits in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs on this clock are to be processed |
| chan_llr | input | 5 | Channel log-likelihood, signed, 2 fraction bits |
| chk_msg_flat | input | 15 | Three check-to-bit messages, edge k at [5k+4:5k] |
| out_valid | output | 1 | Outgoing messages and decision are fresh |
| var_msg_flat | output | 15 | Three bit-to-check messages, edge k at [5k+4:5k] |
| hard_bit | output | 1 | Decided code bit, 1 when the total is negative |

## Verification
All-zero and single-edge patterns show whether an edge's own message leaks into its reply, and whether the edges are packed in the right order. Extreme positive and negative inputs drive every sum past the five-bit limits, which separates saturation from wrap-around. Small negative odd values, such as -1 and -3, tell floor rounding apart from truncation toward zero. A long random run with in_valid toggling is checked against a behavioural integer model. It covers the decision sign and the hold behaviour on idle clocks.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

    localparam int MSG_W = 5;
    localparam int SUM_W = 8;
    localparam int DEG   = 3;

    localparam int MSG_MAX = (2 ** (MSG_W - 1)) - 1;
    localparam int MSG_MIN = -(2 ** (MSG_W - 1));

    typedef logic signed [MSG_W-1:0] msg_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic              hard;
        msg_t [DEG-1:0]    ext;
    } vnu_result_t;

    function automatic sum_t widen(input msg_t m);
        return {{(SUM_W - MSG_W){m[MSG_W-1]}}, m};
    endfunction

    // multiply by 0.75 as half plus quarter, floor rounding
    function automatic sum_t scale_075(input msg_t m);
        sum_t w;
        w = widen(m);
        return (w >>> 1) + (w >>> 2);
    endfunction

    function automatic msg_t clip(input sum_t s);
        sum_t hi;
        sum_t lo;
        hi = sum_t'(MSG_MAX);
        lo = sum_t'(MSG_MIN);
        if (s > hi)      return msg_t'(MSG_MAX);
        else if (s < lo) return msg_t'(MSG_MIN);
        else             return s[MSG_W-1:0];
    endfunction

endpackage

// File: rtl/vnu_scale.sv
module vnu_scale
    import vnu_pkg::*;
#(
    parameter int N = DEG
) (
    input  msg_t [N-1:0] msg_in,
    output sum_t [N-1:0] msg_scaled
);

    for (genvar k = 0; k < N; k++) begin : g_edge
        assign msg_scaled[k] = scale_075(msg_in[k]);
    end

endmodule

// File: rtl/vnu_sum.sv
module vnu_sum
    import vnu_pkg::*;
#(
    parameter int N = DEG
) (
    input  msg_t         chan,
    input  sum_t [N-1:0] scaled,
    output sum_t         total,
    output msg_t [N-1:0] extrinsic
);

    always_comb begin
        total = widen(chan);
        for (int k = 0; k < N; k++) begin
            total = total + scaled[k];
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_ext
        sum_t leave_one_out;
        assign leave_one_out = total - scaled[k];
        assign extrinsic[k]  = clip(leave_one_out);
    end

endmodule

// File: rtl/vnu_core.sv
module vnu_core
    import vnu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [MSG_W-1:0]      chan_llr,
    input  logic [DEG*MSG_W-1:0]  chk_msg_flat,
    output logic                  out_valid,
    output logic [DEG*MSG_W-1:0]  var_msg_flat,
    output logic                  hard_bit
);

    msg_t [DEG-1:0] chk_in;
    sum_t [DEG-1:0] chk_scaled;
    sum_t           total_sum;
    msg_t [DEG-1:0] ext_msg;
    vnu_result_t    res_d;
    vnu_result_t    res_q;
    logic           valid_q;

    assign chk_in = chk_msg_flat;

    vnu_scale #(.N(DEG)) u_scale (
        .msg_in     (chk_in),
        .msg_scaled (chk_scaled)
    );

    vnu_sum #(.N(DEG)) u_sum (
        .chan      (msg_t'(chan_llr)),
        .scaled    (chk_scaled),
        .total     (total_sum),
        .extrinsic (ext_msg)
    );

    always_comb begin
        res_d.hard = total_sum[SUM_W-1];
        res_d.ext  = ext_msg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid    = valid_q;
    assign var_msg_flat = res_q.ext;
    assign hard_bit     = res_q.hard;

endmodule

// File: rtl/vnu_checks.sv
module vnu_checks
    import vnu_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [MSG_W-1:0]     chan_llr,
    input logic [DEG*MSG_W-1:0] chk_msg_flat,
    input logic                 out_valid,
    input logic [DEG*MSG_W-1:0] var_msg_flat,
    input logic                 hard_bit
);

    logic all_neg;
    logic all_nonneg;

    always_comb begin
        all_neg    = chan_llr[MSG_W-1];
        all_nonneg = !chan_llr[MSG_W-1];
        for (int k = 0; k < DEG; k++) begin
            all_neg    = all_neg    &&  chk_msg_flat[k*MSG_W + MSG_W - 1];
            all_nonneg = all_nonneg && !chk_msg_flat[k*MSG_W + MSG_W - 1];
        end
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r5_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !hard_bit && var_msg_flat == '0));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(var_msg_flat) && $stable(hard_bit)));

    a_r4_negative_decides_one: assert property (@(posedge clk) disable iff (rst)
        (in_valid && all_neg) |=> hard_bit);

    a_r4_nonnegative_decides_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && all_nonneg) |=> !hard_bit);

    a_r2_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
        (in_valid && chan_llr == '0 && chk_msg_flat == '0) |=> (var_msg_flat == '0));

endmodule

bind vnu_core vnu_checks u_vnu_checks (.*);

// File: tb/test_vnu_core.sv
module test_vnu_core;

    localparam int CLK_PERIOD = 10;
    localparam int W = 5;
    localparam int D = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [W-1:0]     chan_llr;
    logic [D*W-1:0]   chk_msg_flat;
    logic             out_valid;
    logic [D*W-1:0]   var_msg_flat;
    logic             hard_bit;

    int n_checks = 0;
    int n_fails  = 0;

    int exp_msg [D];
    int exp_hard;
    int exp_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    vnu_core i_vnu_core (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .chan_llr     (chan_llr),
        .chk_msg_flat (chk_msg_flat),
        .out_valid    (out_valid),
        .var_msg_flat (var_msg_flat),
        .hard_bit     (hard_bit)
    );

    function automatic int s5(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - 32 : int'(v);
    endfunction

    function automatic int floor_div(input int a, input int d);
        if (a >= 0) return a / d;
        return -((-a + d - 1) / d);
    endfunction

    function automatic int ref_scale(input int c);
        return floor_div(c, 2) + floor_div(c, 4);
    endfunction

    function automatic int ref_clip(input int s);
        if (s > 15)  return 15;
        if (s < -16) return -16;
        return s;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        string mtag;
        check("R5", "out_valid", int'(out_valid), exp_valid);
        for (int k = 0; k < D; k++) begin
            mtag = tag;
            check(mtag, $sformatf("edge%0d message", k),
                  s5(var_msg_flat[k*W +: W]), exp_msg[k]);
        end
        check((tag == "R7") ? "R7" : "R4", "hard_bit", int'(hard_bit), exp_hard);
    endtask

    // drive one beat at a falling edge, check one clock later
    task automatic apply(input string tag, input bit v, input int ch,
                         input int c0, input int c1, input int c2);
        int c [D];
        int sc [D];
        int tot;
        c[0] = c0; c[1] = c1; c[2] = c2;
        in_valid = v;
        chan_llr = W'(ch);
        chk_msg_flat = {W'(c2), W'(c1), W'(c0)};
        exp_valid = v ? 1 : 0;
        if (v) begin
            tot = ch;
            for (int k = 0; k < D; k++) begin
                sc[k] = ref_scale(c[k]);
                tot += sc[k];
            end
            for (int k = 0; k < D; k++) begin
                exp_msg[k] = ref_clip(tot - sc[k]);
            end
            exp_hard = (tot < 0) ? 1 : 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b1;
        chan_llr = 5'd7;
        chk_msg_flat = '1;
        exp_valid = 0;
        exp_hard = 0;
        for (int k = 0; k < D; k++) exp_msg[k] = 0;
        repeat (3) @(negedge clk);
        compare("R6");
        rst = 1'b0;

        // R2: all zero in gives zero out
        apply("R2", 1'b1, 0, 0, 0, 0);
        // R8: lone message on edge 0 only reaches edges 1 and 2 (8 -> 6)
        apply("R8", 1'b1, 1, 8, 0, 0);
        // R8: lone message on edge 2
        apply("R8", 1'b1, -2, 0, 0, 4);
        // R1: odd negatives round toward minus infinity (-1 -> -2, -3 -> -3)
        apply("R1", 1'b1, 0, -1, -3, 0);
        // R1: positive max scales to 10
        apply("R1", 1'b1, 0, 15, 0, 0);
        // R3: positive saturation
        apply("R3", 1'b1, 15, 15, 15, 15);
        // R3: negative saturation
        apply("R3", 1'b1, -16, -16, -16, -16);
        // R4: total exactly zero decides 0
        apply("R4", 1'b1, -3, 4, 0, 0);
        // R4: total -1 decides 1
        apply("R4", 1'b1, -4, 4, 0, 0);
        // R7: idle clocks hold outputs with garbage on inputs
        apply("R7", 1'b0, 9, -7, 3, 12);
        apply("R7", 1'b0, -11, 5, -16, 2);
        // R2: mixed signs
        apply("R2", 1'b1, 5, -6, 7, -2);

        for (int i = 0; i < 400; i++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            apply(v ? "R2" : "R7", v,
                  $urandom_range(0, 31) - 16, $urandom_range(0, 31) - 16,
                  $urandom_range(0, 31) - 16, $urandom_range(0, 31) - 16);
        end

        // R6: reset in mid-stream clears outputs
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        exp_valid = 0;
        exp_hard = 0;
        for (int k = 0; k < D; k++) exp_msg[k] = 0;
        compare("R6");
        rst = 1'b0;
        apply("R2", 1'b1, 3, 2, 1, -5);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule